// File: doc/BRIEF.md
# Interleaved Half-Pair Lane Transfer

This block moves one 64-byte memory line between memory and one half of an even/odd pair of rows in a 64-row register file. It splits the line into sixteen 32-bit lanes along the way. On a load, the even-numbered lanes of the line go into the chosen half of the even row of the pair. The odd-numbered lanes go into the same half of the odd row. The other half of both rows keeps its contents. On a store, the block reads the chosen half of both rows and puts the lanes back together into one line, alternating even and odd.

The command is a 64-bit operand word, sampled with `cmd_valid` and a direction bit. The operand carries:

- a 56-bit base pointer;
- a half-select bit;
- a 5-bit pair index;
- two top bits that are ignored.

Load data arrives on `ld_line` in the same cycle as the command. The register file sits outside the block and is reached through two combinational read ports and two write ports that share one byte-enable mask. The base pointer is returned with the store line. No address arithmetic is done.

Top module: `ilv_half_xfer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `rf_wr_en` and `st_valid` are 0 and `st_line` is all zeros.
- R2: Operand bits [61:57] give a pair index p. The block addresses rows 2p (even port) and 2p+1 (odd port) on both the read and the write ports.
- R3: Operand bits [63:62] have no effect on any output or on the register-file contents.
- R4: Operand bit 56 selects the half. A value of 0 selects row lanes 0..7 and a value of 1 selects row lanes 8..15. Row lane k occupies row bits [32k+31:32k].
- R5: On a load, memory lane i is `ld_line` bits [32i+31:32i], with byte 4i as its low byte. It is written to row lane h*8 + i/2, in row 2p when i is even and in row 2p+1 when i is odd.
- R6: A load leaves the unselected half of both rows, and every other row, unchanged. With the default byte-enable variant, `rf_wr_be` bit b is 1 exactly when b/32 equals the half bit.
- R7: A load sampled at a clock edge raises `rf_wr_en` for exactly the following cycle. No other cycle has `rf_wr_en` high.
- R8: On a store, line lane 2j equals row 2p lane h*8+j, and line lane 2j+1 equals row 2p+1 lane h*8+j. Each store moves exactly 64 bytes.
- R9: A store sampled at a clock edge gives a one-cycle `st_valid` pulse in the following cycle. `st_line` and `st_ptr` then hold until the next store.
- R10: `st_ptr` equals operand bits [55:0] of the store that produced the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_store | input | 1 | 1 = store (rows to line), 0 = load (line to rows) |
| cmd_op | input | 64 | Operand: pointer, half bit, pair index, ignored top bits |
| ld_line | input | 512 | Memory line for a load, valid with the command |
| rf_rd_addr_ev | output | 6 | Even-row read address |
| rf_rd_addr_od | output | 6 | Odd-row read address |
| rf_rd_data_ev | input | 512 | Even-row read data (combinational) |
| rf_rd_data_od | input | 512 | Odd-row read data (combinational) |
| rf_wr_en | output | 1 | Write both addressed rows at the next edge |
| rf_wr_addr_ev | output | 6 | Even-row write address |
| rf_wr_addr_od | output | 6 | Odd-row write address |
| rf_wr_data_ev | output | 512 | Even-row write data |
| rf_wr_data_od | output | 512 | Odd-row write data |
| rf_wr_be | output | 64 | Byte enables shared by both row writes |
| st_valid | output | 1 | Store line valid pulse |
| st_line | output | 512 | Gathered store line |
| st_ptr | output | 56 | Base pointer of the stored line |

## Verification
The bench loads both halves of the same pair one after the other. A design that wrote full rows, or inverted the byte-enable polarity, would erase the first load, and the bench compares every row of the file after each load to catch it. It uses pairs 0 and 31 and sets the ignored top bits. A slice of the pair field shifted by one bit would hit the wrong row or alias the top bits into the index. Stores read back rows that were written at different times, including a pair only half-loaded, to expose swapped even/odd lanes or a wrong half offset. The bench also changes the operand after a store pulse to show that `st_line` does not follow the read ports.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
package ilv_pkg;
   typedef enum logic {
      HALF_LEFT  = 1'b0,
      HALF_RIGHT = 1'b1
   } half_e;

   // true when row lane k sits in the half picked by h
   function automatic logic lane_in_half(input half_e h, input int unsigned k,
                                         input int unsigned half_lanes);
      return ((k >= half_lanes) == (h == HALF_RIGHT));
   endfunction
endpackage

// File: rtl/ilv_op_decode.sv
`timescale 1ns/1ps
module ilv_op_decode
   import ilv_pkg::*;
#(
   parameter int unsigned OP_W   = 64,
   parameter int unsigned PTR_W  = 56,
   parameter int unsigned PAIR_W = 5
) (
   input  logic [OP_W-1:0]   op,
   output logic [PAIR_W-1:0] pair,
   output half_e             half,
   output logic [PTR_W-1:0]  ptr
);
   localparam int unsigned HALF_BIT = PTR_W;
   localparam int unsigned PAIR_LSB = PTR_W + 1;

   generate
      if (PAIR_LSB + PAIR_W > OP_W) begin : g_bad_fields
         $error("operand too narrow for pointer, half bit and pair index");
      end
   endgenerate

   assign pair = op[PAIR_LSB +: PAIR_W];
   assign half = half_e'(op[HALF_BIT]);
   assign ptr  = op[PTR_W-1:0];

   // bits above the pair field carry no meaning
   logic unused_op;
   assign unused_op = ^op;
endmodule

// File: rtl/ilv_lane_scatter.sv
`timescale 1ns/1ps
module ilv_lane_scatter #(
   parameter int unsigned LANE_W = 32,
   parameter int unsigned LANES  = 16
) (
   input  logic [LANE_W*LANES-1:0] line,
   output logic [LANE_W*LANES-1:0] ev_row,
   output logic [LANE_W*LANES-1:0] od_row
);
   localparam int unsigned HALF = LANES / 2;

   // each split lane is placed in both halves; the write mask or merge picks one
   generate
      for (genvar j = 0; j < HALF; j++) begin : g_slot
         assign ev_row[LANE_W*j        +: LANE_W] = line[LANE_W*(2*j)   +: LANE_W];
         assign ev_row[LANE_W*(HALF+j) +: LANE_W] = line[LANE_W*(2*j)   +: LANE_W];
         assign od_row[LANE_W*j        +: LANE_W] = line[LANE_W*(2*j+1) +: LANE_W];
         assign od_row[LANE_W*(HALF+j) +: LANE_W] = line[LANE_W*(2*j+1) +: LANE_W];
      end
   endgenerate
endmodule

// File: rtl/ilv_lane_gather.sv
`timescale 1ns/1ps
module ilv_lane_gather
   import ilv_pkg::*;
#(
   parameter int unsigned LANE_W = 32,
   parameter int unsigned LANES  = 16
) (
   input  logic [LANE_W*LANES-1:0] ev_row,
   input  logic [LANE_W*LANES-1:0] od_row,
   input  half_e                   half,
   output logic [LANE_W*LANES-1:0] line
);
   localparam int unsigned HALF = LANES / 2;

   logic right;
   assign right = (half == HALF_RIGHT);

   generate
      for (genvar j = 0; j < HALF; j++) begin : g_slot
         assign line[LANE_W*(2*j) +: LANE_W] = right ?
            ev_row[LANE_W*(HALF+j) +: LANE_W] : ev_row[LANE_W*j +: LANE_W];
         assign line[LANE_W*(2*j+1) +: LANE_W] = right ?
            od_row[LANE_W*(HALF+j) +: LANE_W] : od_row[LANE_W*j +: LANE_W];
      end
   endgenerate
endmodule

// File: rtl/ilv_half_xfer.sv
`timescale 1ns/1ps
module ilv_half_xfer
   import ilv_pkg::*;
#(
   parameter int unsigned LANE_W  = 32,
   parameter int unsigned LANES   = 16,
   parameter int unsigned ROWS    = 64,
   parameter int unsigned OP_W    = 64,
   parameter int unsigned PTR_W   = 56,
   parameter bit          USE_RMW = 1'b0,
   localparam int unsigned ROW_W  = LANE_W * LANES,
   localparam int unsigned ROW_B  = ROW_W / 8,
   localparam int unsigned ROW_AW = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_store,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [ROW_W-1:0]  ld_line,
   output logic [ROW_AW-1:0] rf_rd_addr_ev,
   output logic [ROW_AW-1:0] rf_rd_addr_od,
   input  logic [ROW_W-1:0]  rf_rd_data_ev,
   input  logic [ROW_W-1:0]  rf_rd_data_od,
   output logic              rf_wr_en,
   output logic [ROW_AW-1:0] rf_wr_addr_ev,
   output logic [ROW_AW-1:0] rf_wr_addr_od,
   output logic [ROW_W-1:0]  rf_wr_data_ev,
   output logic [ROW_W-1:0]  rf_wr_data_od,
   output logic [ROW_B-1:0]  rf_wr_be,
   output logic              st_valid,
   output logic [ROW_W-1:0]  st_line,
   output logic [PTR_W-1:0]  st_ptr
);
   localparam int unsigned HALF   = LANES / 2;
   localparam int unsigned LANE_B = LANE_W / 8;
   localparam int unsigned PAIR_W = ROW_AW - 1;

   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("LANES must be even and at least 2");
      end
      if ((LANE_W % 8) != 0) begin : g_bad_lane_w
         $error("LANE_W must be a whole number of bytes");
      end
      if (ROWS < 2 || (1 << ROW_AW) != ROWS) begin : g_bad_rows
         $error("ROWS must be a power of two, at least 2");
      end
   endgenerate

   // ---------------- operand decode ----------------
   logic [PAIR_W-1:0] dec_pair;
   half_e             dec_half;
   logic [PTR_W-1:0]  dec_ptr;

   ilv_op_decode #(
      .OP_W  (OP_W),
      .PTR_W (PTR_W),
      .PAIR_W(PAIR_W)
   ) u_dec (
      .op  (cmd_op),
      .pair(dec_pair),
      .half(dec_half),
      .ptr (dec_ptr)
   );

   logic is_load, is_store;
   assign is_load  = cmd_valid && !cmd_store;
   assign is_store = cmd_valid &&  cmd_store;

   assign rf_rd_addr_ev = {dec_pair, 1'b0};
   assign rf_rd_addr_od = {dec_pair, 1'b1};

   // ---------------- load capture stage ----------------
   logic              ld_pend_q;
   logic [PAIR_W-1:0] ld_pair_q;
   half_e             ld_half_q;
   logic [ROW_W-1:0]  ld_line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_pend_q <= 1'b0;
         ld_pair_q <= '0;
         ld_half_q <= HALF_LEFT;
         ld_line_q <= '0;
      end else begin
         ld_pend_q <= is_load;
         if (is_load) begin
            ld_pair_q <= dec_pair;
            ld_half_q <= dec_half;
            ld_line_q <= ld_line;
         end
      end
   end

   logic [ROW_W-1:0] dup_ev, dup_od;

   ilv_lane_scatter #(
      .LANE_W(LANE_W),
      .LANES (LANES)
   ) u_scatter (
      .line  (ld_line_q),
      .ev_row(dup_ev),
      .od_row(dup_od)
   );

   assign rf_wr_en      = ld_pend_q;
   assign rf_wr_addr_ev = {ld_pair_q, 1'b0};
   assign rf_wr_addr_od = {ld_pair_q, 1'b1};

   // ---------------- write variant ----------------
   generate
      if (USE_RMW) begin : g_rmw
         logic [ROW_W-1:0] old_ev_q, old_od_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               old_ev_q <= '0;
               old_od_q <= '0;
            end else if (is_load) begin
               old_ev_q <= rf_rd_data_ev;
               old_od_q <= rf_rd_data_od;
            end
         end

         for (genvar k = 0; k < LANES; k++) begin : g_merge
            logic take_new;
            assign take_new = lane_in_half(ld_half_q, k, HALF);
            assign rf_wr_data_ev[LANE_W*k +: LANE_W] = take_new ?
               dup_ev[LANE_W*k +: LANE_W] : old_ev_q[LANE_W*k +: LANE_W];
            assign rf_wr_data_od[LANE_W*k +: LANE_W] = take_new ?
               dup_od[LANE_W*k +: LANE_W] : old_od_q[LANE_W*k +: LANE_W];
         end
         assign rf_wr_be = '1;
      end else begin : g_byte_en
         assign rf_wr_data_ev = dup_ev;
         assign rf_wr_data_od = dup_od;
         for (genvar k = 0; k < LANES; k++) begin : g_mask
            assign rf_wr_be[LANE_B*k +: LANE_B] =
               {LANE_B{lane_in_half(ld_half_q, k, HALF)}};
         end
      end
   endgenerate

   // ---------------- store path ----------------
   logic [ROW_W-1:0] gath_line;

   ilv_lane_gather #(
      .LANE_W(LANE_W),
      .LANES (LANES)
   ) u_gather (
      .ev_row(rf_rd_data_ev),
      .od_row(rf_rd_data_od),
      .half  (dec_half),
      .line  (gath_line)
   );

   logic             st_valid_q;
   logic [ROW_W-1:0] st_line_q;
   logic [PTR_W-1:0] st_ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_valid_q <= 1'b0;
         st_line_q  <= '0;
         st_ptr_q   <= '0;
      end else begin
         st_valid_q <= is_store;
         if (is_store) begin
            st_line_q <= gath_line;
            st_ptr_q  <= dec_ptr;
         end
      end
   end

   assign st_valid = st_valid_q;
   assign st_line  = st_line_q;
   assign st_ptr   = st_ptr_q;
endmodule

// File: rtl/ilv_half_xfer_chk.sv
`timescale 1ns/1ps
module ilv_half_xfer_chk #(
   parameter int unsigned LANE_W  = 32,
   parameter int unsigned LANES   = 16,
   parameter int unsigned ROWS    = 64,
   parameter int unsigned OP_W    = 64,
   parameter int unsigned PTR_W   = 56,
   parameter bit          USE_RMW = 1'b0,
   localparam int unsigned ROW_W  = LANE_W * LANES,
   localparam int unsigned ROW_B  = ROW_W / 8,
   localparam int unsigned ROW_AW = $clog2(ROWS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_store,
   input logic [OP_W-1:0]   cmd_op,
   input logic [ROW_W-1:0]  rf_rd_data_ev,
   input logic              rf_wr_en,
   input logic [ROW_AW-1:0] rf_wr_addr_ev,
   input logic [ROW_AW-1:0] rf_wr_addr_od,
   input logic [ROW_B-1:0]  rf_wr_be,
   input logic              st_valid,
   input logic [ROW_W-1:0]  st_line,
   input logic [PTR_W-1:0]  st_ptr
);
   localparam int unsigned HALF   = LANES / 2;
   localparam int unsigned PAIR_W = ROW_AW - 1;
   localparam logic [ROW_B-1:0] LO_MASK = ROW_B'({(ROW_B/2){1'b1}});
   localparam logic [ROW_B-1:0] HI_MASK = ~LO_MASK;

   logic unused_chk;
   assign unused_chk = ^{cmd_op, rf_rd_data_ev, st_line};

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!rf_wr_en && !st_valid)); // R1

   AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_store) |=> rf_wr_en); // R7

   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && !cmd_store) |=> !rf_wr_en); // R7

   AST_WR_PAIR_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_store) |=>
         (rf_wr_addr_ev == {$past(cmd_op[PTR_W+1 +: PAIR_W]), 1'b0}) &&
         (rf_wr_addr_od == {$past(cmd_op[PTR_W+1 +: PAIR_W]), 1'b1})); // R2

   generate
      if (!USE_RMW) begin : g_be_chk
         AST_BE_ONE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && !cmd_store) |=>
               (rf_wr_be == ($past(cmd_op[PTR_W]) ? HI_MASK : LO_MASK))); // R6
      end
   endgenerate

   AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_store) |=> st_valid); // R9

   AST_STORE_ONLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_store) |=> !st_valid); // R9

   AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> ($stable(st_line) && $stable(st_ptr))); // R9

   AST_STORE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (st_line[LANE_W-1:0] == ($past(cmd_op[PTR_W]) ?
         $past(rf_rd_data_ev[LANE_W*HALF +: LANE_W]) :
         $past(rf_rd_data_ev[LANE_W-1:0])))); // R8

   AST_STORE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (st_ptr == $past(cmd_op[PTR_W-1:0]))); // R10
endmodule

bind ilv_half_xfer ilv_half_xfer_chk #(
   .LANE_W (LANE_W),
   .LANES  (LANES),
   .ROWS   (ROWS),
   .OP_W   (OP_W),
   .PTR_W  (PTR_W),
   .USE_RMW(USE_RMW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_store    (cmd_store),
   .cmd_op       (cmd_op),
   .rf_rd_data_ev(rf_rd_data_ev),
   .rf_wr_en     (rf_wr_en),
   .rf_wr_addr_ev(rf_wr_addr_ev),
   .rf_wr_addr_od(rf_wr_addr_od),
   .rf_wr_be     (rf_wr_be),
   .st_valid     (st_valid),
   .st_line      (st_line),
   .st_ptr       (st_ptr)
);

// File: tb/sim_ilv_half_xfer.sv
`timescale 1ns/1ps
module sim_ilv_half_xfer;
   localparam int LW  = 32;
   localparam int NL  = 16;
   localparam int NR  = 64;
   localparam int OPW = 64;
   localparam int PW  = 56;
   localparam int RW  = LW * NL;
   localparam int NB  = RW / 8;
   localparam int AW  = 6;
   localparam int PRW = 5;
   localparam int HL  = NL / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_store = 1'b0;
   logic [OPW-1:0] cmd_op = '0;
   logic [RW-1:0] ld_line = '0;
   logic [AW-1:0] rd_addr_ev, rd_addr_od, wr_addr_ev, wr_addr_od;
   logic [RW-1:0] rd_data_ev, rd_data_od, wr_data_ev, wr_data_od, st_line;
   logic          wr_en, st_valid;
   logic [NB-1:0] wr_be;
   logic [PW-1:0] st_ptr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   ilv_half_xfer u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
      .cmd_op(cmd_op), .ld_line(ld_line),
      .rf_rd_addr_ev(rd_addr_ev), .rf_rd_addr_od(rd_addr_od),
      .rf_rd_data_ev(rd_data_ev), .rf_rd_data_od(rd_data_od),
      .rf_wr_en(wr_en), .rf_wr_addr_ev(wr_addr_ev), .rf_wr_addr_od(wr_addr_od),
      .rf_wr_data_ev(wr_data_ev), .rf_wr_data_od(wr_data_od), .rf_wr_be(wr_be),
      .st_valid(st_valid), .st_line(st_line), .st_ptr(st_ptr)
   );

   function automatic logic [RW-1:0] row_init(int r);
      logic [RW-1:0] v;
      for (int k = 0; k < NL; k++)
         v[LW*k +: LW] = {8'(r), 8'(k), 16'h5A00 ^ 16'(r * 37 + k)};
      return v;
   endfunction

   function automatic logic [RW-1:0] mk_line(int s);
      logic [RW-1:0] v;
      for (int i = 0; i < NL; i++)
         v[LW*i +: LW] = 32'((s * 16 + i + 1) * 32'h01000193) ^ 32'hC3D20000;
      return v;
   endfunction

   function automatic logic [OPW-1:0] mk_op(logic [1:0] hi, int p, bit h,
                                            logic [PW-1:0] ptr);
      return {hi, PRW'(p), h, ptr};
   endfunction

   // register file model: combinational read, byte-enabled write
   logic [RW-1:0] rf     [NR];
   logic [RW-1:0] exp_rf [NR];

   assign rd_data_ev = rf[rd_addr_ev];
   assign rd_data_od = rf[rd_addr_od];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NR; r++) rf[r] <= row_init(r);
      end else if (wr_en) begin
         for (int b = 0; b < NB; b++) begin
            if (wr_be[b]) begin
               rf[wr_addr_ev][8*b +: 8] <= wr_data_ev[8*b +: 8];
               rf[wr_addr_od][8*b +: 8] <= wr_data_od[8*b +: 8];
            end
         end
      end
   end

   task automatic check(string req, string what, logic [RW-1:0] act,
                        logic [RW-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic check_rows(string req);
      int bad = 0;
      int first = -1;
      for (int r = 0; r < NR; r++) begin
         if (rf[r] !== exp_rf[r]) begin
            bad++;
            if (first < 0) first = r;
         end
      end
      n_chk++;
      if (bad != 0) begin
         n_err++;
         $display("FAIL %s row %0d of %0d mismatched actual=%h expected=%h",
                  req, first, bad, rf[first], exp_rf[first]);
      end
   endtask

   // R5 R4 R6 R7 R2: one load, then full-file comparison
   task automatic do_load(string tag, logic [1:0] hi, int p, bit h, int seed);
      logic [RW-1:0] line = mk_line(seed);
      for (int i = 0; i < NL; i++) begin
         int row  = 2 * p + (i % 2);
         int lane = (h ? HL : 0) + i / 2;
         exp_rf[row][LW*lane +: LW] = line[LW*i +: LW];
      end
      @(negedge clk);
      cmd_valid = 1'b1; cmd_store = 1'b0;
      cmd_op = mk_op(hi, p, h, PW'(seed * 4097)); ld_line = line;
      #1;
      check("R2", {tag, " read addr even"}, RW'(rd_addr_ev), RW'(2 * p));
      @(negedge clk);
      cmd_valid = 1'b0; ld_line = ~line; cmd_op = ~cmd_op;
      check("R7", {tag, " write enable in following cycle"}, RW'(wr_en), RW'(1));
      check("R2", {tag, " write addr even"}, RW'(wr_addr_ev), RW'(2 * p));
      check("R2", {tag, " write addr odd"}, RW'(wr_addr_od), RW'(2 * p + 1));
      @(negedge clk);
      check("R7", {tag, " write enable drops"}, RW'(wr_en), RW'(0));
      check("R5", {tag, " even row"}, rf[2 * p], exp_rf[2 * p]);
      check("R5", {tag, " odd row"}, rf[2 * p + 1], exp_rf[2 * p + 1]);
      check_rows({"R6 ", tag});
   endtask

   // R8 R9 R10: one store, then hold check
   task automatic do_store(string tag, logic [1:0] hi, int p, bit h,
                           logic [PW-1:0] ptr);
      logic [RW-1:0] expv;
      for (int i = 0; i < NL; i++)
         expv[LW*i +: LW] = exp_rf[2 * p + (i % 2)][LW*((h ? HL : 0) + i / 2) +: LW];
      @(negedge clk);
      cmd_valid = 1'b1; cmd_store = 1'b1; cmd_op = mk_op(hi, p, h, ptr);
      #1;
      check("R2", {tag, " read addr odd"}, RW'(rd_addr_od), RW'(2 * p + 1));
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = mk_op(2'b00, (p + 3) % 32, !h, ~ptr);
      check("R9", {tag, " valid pulse"}, RW'(st_valid), RW'(1));
      check("R8", {tag, " gathered line"}, st_line, expv);
      check("R10", {tag, " pointer"}, RW'(st_ptr), RW'(ptr));
      @(negedge clk);
      check("R9", {tag, " pulse ends"}, RW'(st_valid), RW'(0));
      check("R9", {tag, " line held"}, st_line, expv);
      check("R7", {tag, " no write on store"}, RW'(wr_en), RW'(0));
   endtask

   task automatic t_reset();
      for (int r = 0; r < NR; r++) exp_rf[r] = row_init(r);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "write enable in reset", RW'(wr_en), RW'(0));
      check("R1", "store valid in reset", RW'(st_valid), RW'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "store line after reset", st_line, '0);
      check("R1", "write enable after reset", RW'(wr_en), RW'(0));
   endtask

   initial begin
      t_reset();
      do_load("R4 left pair0", 2'b00, 0, 1'b0, 1);
      do_load("R4 right pair0", 2'b00, 0, 1'b1, 2);
      do_load("R3 top bits pair31", 2'b11, 31, 1'b1, 3);
      do_load("R3 top bits pair5", 2'b10, 5, 1'b0, 4);
      do_store("R4 left pair0", 2'b00, 0, 1'b0, 56'h00_1234_5678_9ABC);
      do_store("R4 right pair0", 2'b00, 0, 1'b1, 56'hFF_FFFF_FFFF_FFC0);
      do_store("R3 top bits pair31", 2'b01, 31, 1'b1, 56'h80_0000_0000_0040);
      do_store("untouched pair7", 2'b00, 7, 1'b0, 56'h00_0000_0000_0000);
      do_store("half loaded pair5 right", 2'b11, 5, 1'b1, 56'h12_0000_0000_1000);
      do_store("half loaded pair5 left", 2'b00, 5, 1'b0, 56'h34_0000_0000_2000);
      do_load("R6 overwrite pair31 left", 2'b01, 31, 1'b0, 9);
      do_store("R8 pair31 left", 2'b00, 31, 1'b0, 56'h00_00AB_CDEF_0000);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired before all scenarios ended");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule